// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block lets a node place its one-byte identifier into the in-frame response window of a shared wired-AND serial bus. A value of 0 on the bus is active and dominant, and a value of 1 is passive. The block works at bit-slot level. A symbol decoder upstream supplies an end-of-data strobe, an end-of-frame strobe, and a per-slot strobe with the bus value received in that slot. The block returns the value the node wants on the bus in the current slot. The pulse-width timing, the CRC and the physical driver sit outside the block.

A three-bit response-type register holds three bits: a single-byte bit, a multi-byte bit and a multi-byte-with-check bit. These bits pass through a fixed-priority encoder. Software reads back the bits exactly as it wrote them, while the sequencer acts on the encoded code.

After end-of-data the node drives one active normalization slot, then its identifier MSB first. If the node loses arbitration, it stops driving for the rest of that byte. In the multi-byte types it tries again at the next byte boundary, and keeps doing so until its own byte appears intact in the response stream. A completion pulse marks that event. End-of-frame, a loss in single-byte type, or too many bytes in the response each abort the response and raise an error flag.

Top module: `ifr_tx_seq`

## Requirements
- R1: `mode_code` is the priority encoding of the written bits, with bit 2 = single-byte, bit 1 = multi-byte and bit 0 = multi-byte-with-check. Bit 2 beats both other bits and bit 1 beats bit 0: 1XX gives 100, 01X gives 010, 001 gives 001, 000 gives 000.
- R2: `mode_rdata` returns the raw bits last written through `mode_wr`, even when several are set (written 011 reads 011 while `mode_code` is 010).
- R3: `tx_bit` stays 1 (passive) while no response is in progress. This covers slots before any end-of-data, and end-of-data while `mode_code` is 000.
- R4: In the slot that follows an accepted end-of-data, `tx_bit` is 0 (normalization, with `NORM_BIT`=1). The next 8 slots carry `node_id` MSB first.
- R5: A slot where the node offers 1 but receives 0 sets `arb_lost`. `tx_bit` then stays 1 for the rest of that byte, and `arb_lost` clears at the byte boundary.
- R6: In the multi-byte types, a byte that does not equal `node_id` is followed at once, with no new normalization slot, by a fresh copy of `node_id` starting at its MSB.
- R7: `done` is high for exactly one clock, in the cycle after the slot strobe that completes a received byte equal to `node_id`. The sequencer is then idle.
- R8: In single-byte type, a received byte not equal to `node_id` sets `err` and ends the response without a retry.
- R9: When `MAX_BYTES` (default 8) response bytes complete without a match, `err` is set and the sequencer goes idle. `err` stays 0 after `MAX_BYTES`-1 such bytes.
- R10: `eof` during a response sets `err` in the next cycle and idles the sequencer. `err` clears when the next response is accepted, and `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Write strobe for the response-type bits |
| mode_wdata | input | 3 | Raw response-type bits {single, multi, multi-check} |
| mode_rdata | output | 3 | Raw bits as last written |
| mode_code | output | 3 | Priority-encoded response type |
| node_id | input | ID_W | This node's identifier byte |
| eod | input | 1 | End-of-data strobe from the symbol decoder |
| eof | input | 1 | End-of-frame strobe from the symbol decoder |
| slot | input | 1 | One-clock strobe at the end of each bit slot |
| rx_bit | input | 1 | Bus value received in the slot marked by `slot` |
| tx_bit | output | 1 | Value requested on the bus for the current slot (0 = active) |
| arb_lost | output | 1 | Arbitration lost in the current byte |
| done | output | 1 | One-clock pulse: own identifier confirmed on the bus |
| err | output | 1 | Response aborted |

## Verification
The bench writes overlapping mode-bit patterns. A wrong priority order or a read path that returns the encoded code would show up as a mismatched `mode_code` or `mode_rdata`. It loses arbitration on the first bit of a byte, so that the retry must open with a passive identifier MSB. A design that inserts a second normalization slot or keeps driving after a loss would put 0 on the bus where 1 is expected. The bench also drives a response to the byte limit and aborts another one mid-byte with end-of-frame. An off-by-one limit counter or a missed abort would either flag the error one byte early or late, or leave the node driving after the frame has closed.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_NORM = 2'd1,
      ST_SEND = 2'd2
   } seq_state_t;
endpackage

// File: rtl/ifr_mode_reg.sv
module ifr_mode_reg #(
   parameter int MODE_W = ifr_pkg::MODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [MODE_W-1:0] wdata_i,
   output logic [MODE_W-1:0] raw_o,
   output logic [MODE_W-1:0] code_o
);
   logic [MODE_W-1:0] raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    raw_q <= '0;
      else if (wr_i) raw_q <= wdata_i;
   end

   // highest index has highest priority
   for (genvar g = 0; g < MODE_W; g++) begin : g_pri
      if (g == MODE_W - 1) begin : g_top
         assign code_o[g] = raw_q[g];
      end else begin : g_low
         assign code_o[g] = raw_q[g] & ~(|raw_q[MODE_W-1:g+1]);
      end
   end

   assign raw_o = raw_q;
endmodule

// File: rtl/ifr_byte_arb.sv
module ifr_byte_arb #(
   parameter int ID_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            run_i,
   input  logic            slot_i,
   input  logic            rx_bit_i,
   input  logic [ID_W-1:0] id_i,
   output logic            tx_bit_o,
   output logic            byte_end_o,
   output logic [ID_W-1:0] rx_byte_o,
   output logic            lost_o
);
   localparam int CNT_W = $clog2(ID_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ID_W - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [ID_W-1:0]  tx_sh_q;
   logic [ID_W-2:0]  rx_sh_q;
   logic             lost_q;

   assign tx_bit_o   = run_i ? (lost_q | tx_sh_q[ID_W-1]) : 1'b1;
   assign byte_end_o = run_i & slot_i & (cnt_q == LAST);
   assign rx_byte_o  = {rx_sh_q, rx_bit_i};
   assign lost_o     = lost_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         tx_sh_q <= '1;
         rx_sh_q <= '0;
         lost_q  <= 1'b0;
      end else if (start_i) begin
         cnt_q   <= '0;
         tx_sh_q <= id_i;
         lost_q  <= 1'b0;
      end else if (run_i && slot_i) begin
         rx_sh_q <= rx_byte_o[ID_W-2:0];
         if (byte_end_o) begin
            cnt_q   <= '0;
            tx_sh_q <= id_i;
            lost_q  <= 1'b0;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
            tx_sh_q <= {tx_sh_q[ID_W-2:0], 1'b1};
            if (tx_bit_o && !rx_bit_i) lost_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ifr_tx_seq.sv
module ifr_tx_seq
   import ifr_pkg::*;
#(
   parameter int ID_W      = 8,
   parameter int MAX_BYTES = 8,
   parameter bit NORM_BIT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_wdata,
   output logic [MODE_W-1:0] mode_rdata,
   output logic [MODE_W-1:0] mode_code,
   input  logic [ID_W-1:0]   node_id,
   input  logic              eod,
   input  logic              eof,
   input  logic              slot,
   input  logic              rx_bit,
   output logic              tx_bit,
   output logic              arb_lost,
   output logic              done,
   output logic              err
);
   localparam int BC_W = $clog2(MAX_BYTES + 1);
   localparam logic [BC_W-1:0] BC_LAST = BC_W'(MAX_BYTES - 1);

   if (ID_W < 2) begin : g_chk_id
      $error("ifr_tx_seq: ID_W must be at least 2");
   end
   if (MAX_BYTES < 1) begin : g_chk_max
      $error("ifr_tx_seq: MAX_BYTES must be at least 1");
   end

   seq_state_t      state_q, first_st;
   logic            single_q, done_q, err_q;
   logic [BC_W-1:0] bc_q;
   logic            accept, arb_tx, byte_end;
   logic [ID_W-1:0] rx_byte;

   if (NORM_BIT) begin : g_norm
      assign first_st = ST_NORM;
   end else begin : g_nonorm
      assign first_st = ST_SEND;
   end

   ifr_mode_reg #(.MODE_W(MODE_W)) mode_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (mode_wr),
      .wdata_i(mode_wdata),
      .raw_o  (mode_rdata),
      .code_o (mode_code)
   );

   assign accept = (state_q == ST_IDLE) && eod && (|mode_code);

   ifr_byte_arb #(.ID_W(ID_W)) arb_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (accept),
      .run_i     (state_q == ST_SEND),
      .slot_i    (slot),
      .rx_bit_i  (rx_bit),
      .id_i      (node_id),
      .tx_bit_o  (arb_tx),
      .byte_end_o(byte_end),
      .rx_byte_o (rx_byte),
      .lost_o    (arb_lost)
   );

   assign tx_bit = (state_q == ST_NORM) ? 1'b0 : arb_tx;
   assign done   = done_q;
   assign err    = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         single_q <= 1'b0;
         bc_q     <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q  <= first_st;
                  single_q <= mode_code[MODE_W-1];
                  bc_q     <= '0;
                  err_q    <= 1'b0;
               end
            end
            ST_NORM: begin
               if (eof) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (slot) begin
                  state_q <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (eof) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (byte_end) begin
                  if (rx_byte == node_id) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (single_q || bc_q == BC_LAST) begin
                     err_q   <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     bc_q <= bc_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ifr_tx_seq_chk.sv
module ifr_tx_seq_chk
   import ifr_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input seq_state_t state_q,
   input logic       tx_bit,
   input logic [2:0] mode_rdata,
   input logic [2:0] mode_code,
   input logic       done,
   input logic       err,
   input logic       arb_lost,
   input logic       eof
);
   p_code_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mode_code));

   p_single_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mode_rdata[2] |-> (mode_code == 3'b100));

   p_idle_passive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> tx_bit);

   p_lost_passive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> tx_bit);

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (state_q == ST_IDLE));

   p_eof_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eof && state_q != ST_IDLE) |=> (err && state_q == ST_IDLE));

   p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));
endmodule

bind ifr_tx_seq ifr_tx_seq_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .state_q   (state_q),
   .tx_bit    (tx_bit),
   .mode_rdata(mode_rdata),
   .mode_code (mode_code),
   .done      (done),
   .err       (err),
   .arb_lost  (arb_lost),
   .eof       (eof)
);

// File: tb/ifr_tx_seq_tb_top.sv
`timescale 1ns/1ps
module ifr_tx_seq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 1'b0;
   logic [2:0] mode_wdata = '0;
   logic [2:0] mode_rdata, mode_code;
   logic [7:0] node_id = 8'hA5;
   logic       eod = 1'b0, eof = 1'b0, slot = 1'b0, rx_bit = 1'b1;
   logic       tx_bit, arb_lost, done, err;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ifr_tx_seq dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .mode_rdata(mode_rdata), .mode_code(mode_code), .node_id(node_id),
      .eod(eod), .eof(eof), .slot(slot), .rx_bit(rx_bit), .tx_bit(tx_bit),
      .arb_lost(arb_lost), .done(done), .err(err)
   );

   // {written bits, expected code}
   localparam logic [5:0] MODE_VEC [8] = '{
      {3'b000, 3'b000}, {3'b001, 3'b001}, {3'b010, 3'b010}, {3'b011, 3'b010},
      {3'b100, 3'b100}, {3'b101, 3'b100}, {3'b110, 3'b100}, {3'b111, 3'b100}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_mode(input logic [2:0] v);
      mode_wr = 1'b1; mode_wdata = v;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   task automatic pulse_eod();
      eod = 1'b1;
      @(negedge clk);
      eod = 1'b0;
   endtask

   // one slot: bus value = own request AND the other responder
   task automatic do_slot(input logic other, output logic seen);
      seen = tx_bit;
      slot = 1'b1; rx_bit = tx_bit & other;
      @(negedge clk);
      slot = 1'b0; rx_bit = 1'b1;
   endtask

   task automatic send_byte(input logic [7:0] other, output logic [7:0] seen);
      for (int i = 7; i >= 0; i--) begin
         logic b;
         do_slot(other[i], b);
         seen[i] = b;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic       b;
      logic [7:0] sb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(tx_bit == 1'b1, "R3 reset tx", tx_bit, 1);
      chk(done == 1'b0 && err == 1'b0, "R10 reset flags", {done, err}, 0);
      chk(mode_rdata == 3'b000, "R2 reset readback", mode_rdata, 0);
      chk(arb_lost == 1'b0, "R5 reset lost", arb_lost, 0);

      // table of mode-bit writes
      for (int k = 0; k < 8; k++) begin
         write_mode(MODE_VEC[k][5:3]);
         chk(mode_code == MODE_VEC[k][2:0], "R1 priority code", mode_code, MODE_VEC[k][2:0]);
         chk(mode_rdata == MODE_VEC[k][5:3], "R2 raw readback", mode_rdata, MODE_VEC[k][5:3]);
      end

      // R3: slots before any end-of-data stay passive
      write_mode(3'b010);
      do_slot(1'b1, b);
      chk(b == 1'b1, "R3 passive before eod", b, 1);

      // R3: end-of-data with no response type
      write_mode(3'b000);
      pulse_eod();
      do_slot(1'b1, b);
      chk(b == 1'b1, "R3 mode 000 no response", b, 1);

      // R4/R7: clean response, no competitor
      write_mode(3'b011);
      chk(mode_rdata == 3'b011 && mode_code == 3'b010, "R2 overlap readback",
          {mode_rdata, mode_code}, {3'b011, 3'b010});
      pulse_eod();
      do_slot(1'b1, b);
      chk(b == 1'b0, "R4 normalization active", b, 0);
      send_byte(8'hFF, sb);
      chk(sb == 8'hA5, "R4 id msb first", sb, 8'hA5);
      chk(done == 1'b1, "R7 done after match", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R7 done one clock", done, 0);
      chk(tx_bit == 1'b1, "R7 idle after done", tx_bit, 1);

      // R5/R6: lose on the first bit, retry without normalization
      write_mode(3'b010);
      pulse_eod();
      do_slot(1'b1, b);
      sb = 8'h3C;
      do_slot(sb[7], b);
      chk(arb_lost == 1'b1, "R5 lost flagged", arb_lost, 1);
      chk(tx_bit == 1'b1, "R5 passive after loss", tx_bit, 1);
      for (int i = 6; i >= 0; i--) do_slot(sb[i], b);
      chk(arb_lost == 1'b0 && done == 1'b0, "R5 lost cleared at boundary",
          {arb_lost, done}, 0);
      chk(tx_bit == 1'b1, "R6 retry opens with id msb", tx_bit, 1);
      send_byte(8'hFF, sb);
      chk(sb == 8'hA5, "R6 retried id", sb, 8'hA5);
      chk(done == 1'b1, "R7 done after retry", done, 1);

      // R8: single-byte type gives up on loss
      write_mode(3'b110);
      pulse_eod();
      do_slot(1'b1, b);
      send_byte(8'h00, sb);
      chk(err == 1'b1 && done == 1'b0, "R8 single-byte error", {err, done}, 2'b10);
      do_slot(1'b1, b);
      chk(b == 1'b1, "R8 no retry", b, 1);

      // R9: byte limit in multi-byte type
      write_mode(3'b010);
      pulse_eod();
      chk(err == 1'b0, "R10 err cleared at accept", err, 0);
      do_slot(1'b1, b);
      for (int n = 0; n < 7; n++) send_byte(8'h00, sb);
      chk(err == 1'b0, "R9 no error before limit", err, 0);
      send_byte(8'h00, sb);
      chk(err == 1'b1, "R9 error at limit", err, 1);
      do_slot(1'b1, b);
      chk(b == 1'b1, "R9 idle after limit", b, 1);

      // R10: end-of-frame abort mid-byte
      write_mode(3'b001);
      pulse_eod();
      do_slot(1'b1, b);
      for (int i = 0; i < 3; i++) do_slot(1'b1, b);
      eof = 1'b1;
      @(negedge clk);
      eof = 1'b0;
      chk(err == 1'b1, "R10 eof abort", err, 1);
      chk(tx_bit == 1'b1, "R10 passive after abort", tx_bit, 1);

      // R10: next response clears err and completes
      pulse_eod();
      chk(err == 1'b0, "R10 err cleared", err, 0);
      do_slot(1'b1, b);
      send_byte(8'hFF, sb);
      chk(sb == 8'hA5 && done == 1'b1, "R7 done after recovery", {sb, done}, {8'hA5, 1'b1});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule